// File: doc/BRIEF.md
# Real-Time Clock Status and Interrupt Controller

This block holds the status and interrupt logic of a real-time clock and presents it to a CPU through a plain write-strobe register port. An external time counter running on a slow 32 kHz clock supplies one-cycle strobes when the second, minute, hour or day rolls over, when the alarm time matches, and when the chosen periodic interval elapses. It also supplies a level that warns of an update that is about to happen. The block carries every strobe into the fast bus-clock domain, records it in an 8-bit status register and drives two active-low interrupt lines. The alarm line is a held level. The timer line is a pulse of fixed length.

The CPU stops the clock with a stop-request level. That level is captured on the slow clock and becomes the run enable sent back to the counter. The RUN status bit is taken from that enable after it has been brought back into the bus domain, so it shows the clock's actual state and not the request. The power-up and alarm flags are cleared by writing 1 to them. Writing 0 to them does nothing. A second register holds the two interrupt enables.

The timer pulse is generated by a two-state machine. In `TP_IDLE` the line is high. The transition `TP_IDLE -> TP_LOW` is taken when a synchronized periodic strobe arrives while the timer enable is set. In `TP_LOW` the line is low and a down-counter runs. The transition `TP_LOW -> TP_IDLE` is taken when the counter reaches zero. A periodic strobe that arrives while the machine is in `TP_LOW` is dropped.

Top module: `rtc_stat_ctrl`

## Requirements
- R1: While reset is asserted, the status output reads 0x80, the interrupt-enable output reads 0x00, the run enable is 0, and both interrupt lines are high.
- R2: Status bit 7 (power-up) is set only by reset. It clears when the CPU writes status (`wr_sel_i`=0) with data bit 7 at 1. Writing that bit as 0 leaves it set.
- R3: An alarm strobe sets status bit 6 whether or not interrupts are enabled. `alarm_irq_n_o` goes low only if interrupt-enable bit 3 is set when the strobe is registered.
- R4: Once low, `alarm_irq_n_o` stays low until a status write with data bit 6 at 1. That write also clears status bit 6. A status write with bit 6 at 0 changes neither of them.
- R5: A periodic strobe registered while interrupt-enable bit 2 is set drives `timer_irq_n_o` low for exactly PULSE_W bus-clock cycles, once per strobe. With bit 2 clear, the line stays high.
- R6: The run enable falls no later than one slow-clock period after `stop_req_i` rises, and rises again within one period after it falls. Status bit 1 (RUN) follows the run enable after bus-domain synchronization.
- R7: Status bit 0 (BUSY) reads 1 while the counter's update-warning level is high, so it is visible before the second strobe that follows.
- R8: Status bits 5..2 show day, hour, minute and second (bit 5 down to bit 2) for the most recent set of time strobes. Each time-strobe event reloads all four bits. CPU writes do not change them.
- R9: An interrupt-enable write (`wr_sel_i`=1) stores data bits 3 (alarm enable) and 2 (timer enable). All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| rtc_clk | input | 1 | 32 kHz time-base clock |
| evt_sec_i | input | 1 | Second rollover strobe, one rtc_clk cycle |
| evt_min_i | input | 1 | Minute rollover strobe |
| evt_hour_i | input | 1 | Hour rollover strobe |
| evt_day_i | input | 1 | Day rollover strobe |
| alarm_hit_i | input | 1 | Alarm match strobe |
| period_hit_i | input | 1 | Periodic interval strobe |
| upd_soon_i | input | 1 | Level warning that an update is imminent (rtc_clk domain) |
| stop_req_i | input | 1 | CPU request to freeze the clock (bus domain level) |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 status, 1 interrupt enable |
| wr_data_i | input | 8 | Write data |
| status_o | output | 8 | Status register |
| irq_en_o | output | 8 | Interrupt-enable register |
| run_o | output | 1 | Run enable to the time counter |
| alarm_irq_n_o | output | 1 | Active-low held alarm interrupt |
| timer_irq_n_o | output | 1 | Active-low periodic interrupt pulse |

## Verification
The bench writes 0 to the write-one-to-clear bits and checks that the flags survive. A design that treated every write as a plain store would lose the power-up or alarm flag at that point. It keeps the alarm line low across long idle stretches and across writes that do not clear it, which exposes a line that self-clears or one that is cleared by the wrong data bit. It counts the exact number of low cycles on the timer line and checks that a disabled timer produces none, which catches an off-by-one counter, a retriggering pulse or a missing enable gate. It times how long the run enable takes to fall after a stop request and checks that BUSY is visible before a second strobe. A second synchronizer stage in the stop path, or a RUN bit taken from the request, would fail these checks.

// File: rtl/rtc_stat_pkg.sv
package rtc_stat_pkg;

    localparam int STAT_W  = 8;

    // status bit positions (software decodes these)
    localparam int B_PWR   = 7;
    localparam int B_ALM   = 6;
    localparam int B_DAY   = 5;
    localparam int B_HOUR  = 4;
    localparam int B_MIN   = 3;
    localparam int B_SEC   = 2;
    localparam int B_RUN   = 1;
    localparam int B_BUSY  = 0;

    // interrupt-enable bit positions
    localparam int IE_ALM  = 3;
    localparam int IE_TMR  = 2;
    localparam logic [STAT_W-1:0] IE_WMASK = STAT_W'((1 << IE_ALM) | (1 << IE_TMR));

    // strobe channels crossing from the slow domain
    localparam int N_CH    = 6;
    localparam int CH_SEC  = 0;
    localparam int CH_MIN  = 1;
    localparam int CH_HOUR = 2;
    localparam int CH_DAY  = 3;
    localparam int CH_ALM  = 4;
    localparam int CH_PER  = 5;

    typedef enum logic {
        TP_IDLE = 1'b0,
        TP_LOW  = 1'b1
    } tpulse_e;

endpackage

// File: rtl/rtc_toggle_sync.sv
// Carries a one-cycle strobe from the slow clock into the bus clock.
// The slow side flips a toggle; the bus side turns each edge of the
// synchronized toggle into one bus-cycle pulse.
module rtc_toggle_sync #(
    parameter int STAGES = 2
) (
    input  logic rtc_clk,
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    output logic pulse_o
);

    logic          tog_q;
    logic [STAGES:0] sh_q;

    always_ff @(posedge rtc_clk or negedge rst_n) begin
        if (!rst_n) begin
            tog_q <= 1'b0;
        end else begin
            tog_q <= tog_q ^ strobe_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= {sh_q[STAGES-1:0], tog_q};
        end
    end

    assign pulse_o = sh_q[STAGES] ^ sh_q[STAGES-1];

endmodule

// File: rtl/rtc_level_sync.sv
// Multi-flop synchronizer for quasi-static levels.
module rtc_level_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [STAGES-1:0][W-1:0] st_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= {st_q[STAGES-2:0], d_i};
        end
    end

    assign q_o = st_q[STAGES-1];

endmodule

// File: rtl/rtc_pulse_fsm.sv
// Fixed-width active-low pulse generator for the periodic interrupt.
module rtc_pulse_fsm
    import rtc_stat_pkg::*;
#(
    parameter int PULSE_W = 3000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    output logic irq_n_o
);

    localparam int CNT_W = (PULSE_W < 2) ? 1 : $clog2(PULSE_W);

    tpulse_e           state_q;
    logic [CNT_W-1:0]  cnt_q;

    // state register and transitions
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TP_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                TP_IDLE: begin
                    if (fire_i) begin
                        state_q <= TP_LOW;
                        cnt_q   <= CNT_W'(PULSE_W - 1);
                    end
                end
                TP_LOW: begin
                    if (cnt_q == '0) begin
                        state_q <= TP_IDLE;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: state_q <= TP_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            TP_LOW:  irq_n_o = 1'b0;
            default: irq_n_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/rtc_stat_ctrl.sv
module rtc_stat_ctrl
    import rtc_stat_pkg::*;
#(
    parameter int PULSE_W     = 3000,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rtc_clk,
    input  logic              evt_sec_i,
    input  logic              evt_min_i,
    input  logic              evt_hour_i,
    input  logic              evt_day_i,
    input  logic              alarm_hit_i,
    input  logic              period_hit_i,
    input  logic              upd_soon_i,
    input  logic              stop_req_i,
    input  logic              wr_en_i,
    input  logic              wr_sel_i,
    input  logic [STAT_W-1:0] wr_data_i,
    output logic [STAT_W-1:0] status_o,
    output logic [STAT_W-1:0] irq_en_o,
    output logic              run_o,
    output logic              alarm_irq_n_o,
    output logic              timer_irq_n_o
);

    localparam logic [STAT_W-1:0] M_PWR = STAT_W'(1 << B_PWR);
    localparam logic [STAT_W-1:0] M_ALM = STAT_W'(1 << B_ALM);

    logic [N_CH-1:0] strobe_raw;
    logic [N_CH-1:0] strobe_bus;

    assign strobe_raw[CH_SEC]  = evt_sec_i;
    assign strobe_raw[CH_MIN]  = evt_min_i;
    assign strobe_raw[CH_HOUR] = evt_hour_i;
    assign strobe_raw[CH_DAY]  = evt_day_i;
    assign strobe_raw[CH_ALM]  = alarm_hit_i;
    assign strobe_raw[CH_PER]  = period_hit_i;

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        rtc_toggle_sync #(
            .STAGES (SYNC_STAGES)
        ) u_sync (
            .rtc_clk  (rtc_clk),
            .clk      (clk),
            .rst_n    (rst_n),
            .strobe_i (strobe_raw[ch]),
            .pulse_o  (strobe_bus[ch])
        );
    end

    // stop request captured once on the slow clock: at most one period of lag
    logic run_q;

    always_ff @(posedge rtc_clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 1'b0;
        end else begin
            run_q <= !stop_req_i;
        end
    end

    assign run_o = run_q;

    logic [1:0] lvl_bus;

    rtc_level_sync #(
        .W      (2),
        .STAGES (SYNC_STAGES)
    ) u_lvl (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({run_q, upd_soon_i}),
        .q_o   (lvl_bus)
    );

    // bus-side register state
    logic              pwr_q;
    logic              alm_flag_q;
    logic              alm_irq_q;
    logic [3:0]        evt_q;
    logic [STAT_W-1:0] ie_q;

    logic stat_wr;
    logic ie_wr;
    logic clr_pwr;
    logic clr_alm;
    logic any_time;
    logic alm_set;
    logic tmr_fire;

    assign stat_wr  = wr_en_i && (wr_sel_i == 1'b0);
    assign ie_wr    = wr_en_i && (wr_sel_i == 1'b1);
    assign clr_pwr  = stat_wr && |(wr_data_i & M_PWR);
    assign clr_alm  = stat_wr && |(wr_data_i & M_ALM);
    assign any_time = |strobe_bus[CH_DAY:CH_SEC];
    assign alm_set  = strobe_bus[CH_ALM];
    assign tmr_fire = strobe_bus[CH_PER] && ie_q[IE_TMR];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwr_q <= 1'b1;
        end else if (clr_pwr) begin
            pwr_q <= 1'b0;
        end
    end

    // a new alarm in the same cycle as a clear wins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alm_flag_q <= 1'b0;
            alm_irq_q  <= 1'b0;
        end else begin
            if (alm_set) begin
                alm_flag_q <= 1'b1;
            end else if (clr_alm) begin
                alm_flag_q <= 1'b0;
            end
            if (alm_set && ie_q[IE_ALM]) begin
                alm_irq_q <= 1'b1;
            end else if (clr_alm) begin
                alm_irq_q <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_q <= '0;
        end else if (any_time) begin
            evt_q <= {strobe_bus[CH_DAY], strobe_bus[CH_HOUR],
                      strobe_bus[CH_MIN], strobe_bus[CH_SEC]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie_q <= '0;
        end else if (ie_wr) begin
            ie_q <= wr_data_i & IE_WMASK;
        end
    end

    rtc_pulse_fsm #(
        .PULSE_W (PULSE_W)
    ) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire_i  (tmr_fire),
        .irq_n_o (timer_irq_n_o)
    );

    always_comb begin
        status_o          = '0;
        status_o[B_PWR]   = pwr_q;
        status_o[B_ALM]   = alm_flag_q;
        status_o[B_DAY]   = evt_q[3];
        status_o[B_HOUR]  = evt_q[2];
        status_o[B_MIN]   = evt_q[1];
        status_o[B_SEC]   = evt_q[0];
        status_o[B_RUN]   = lvl_bus[1];
        status_o[B_BUSY]  = lvl_bus[0];
    end

    assign irq_en_o      = ie_q;
    assign alarm_irq_n_o = !alm_irq_q;

endmodule

// File: rtl/rtc_stat_chk.sv
module rtc_stat_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rtc_clk,
    input logic       stop_req_i,
    input logic       wr_en_i,
    input logic       wr_sel_i,
    input logic [7:0] wr_data_i,
    input logic [7:0] status_o,
    input logic [7:0] irq_en_o,
    input logic       run_o,
    input logic       alarm_irq_n_o,
    input logic       timer_irq_n_o
);

    // R2: once cleared, power-up flag never returns outside reset
    p_pwr_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !status_o[7] |=> !status_o[7]);

    // R3: a low alarm line always comes with the alarm flag
    p_alarm_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !alarm_irq_n_o |-> status_o[6]);

    // R4: alarm line stays low unless cleared by a write-one
    p_alarm_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!alarm_irq_n_o && !(wr_en_i && !wr_sel_i && wr_data_i[6]))
        |=> !alarm_irq_n_o);

    // R5: a timer pulse begins only with the timer enable set
    p_timer_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(timer_irq_n_o) |-> $past(irq_en_o[2]));

    // R6: a stop request held across a slow edge has frozen the clock
    p_run_stop_r6: assert property (@(posedge rtc_clk) disable iff (!rst_n)
        (stop_req_i && $past(stop_req_i)) |-> !run_o);

    // R9: enable write stores data bits 3 and 2
    p_ie_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_sel_i) |=> (irq_en_o[3:2] == $past(wr_data_i[3:2])));

endmodule

bind rtc_stat_ctrl rtc_stat_chk i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rtc_clk       (rtc_clk),
    .stop_req_i    (stop_req_i),
    .wr_en_i       (wr_en_i),
    .wr_sel_i      (wr_sel_i),
    .wr_data_i     (wr_data_i),
    .status_o      (status_o),
    .irq_en_o      (irq_en_o),
    .run_o         (run_o),
    .alarm_irq_n_o (alarm_irq_n_o),
    .timer_irq_n_o (timer_irq_n_o)
);

// File: tb/test_rtc_stat_ctrl.sv
`timescale 1ns/1ps
module test_rtc_stat_ctrl;

    localparam int PW = 24;

    logic       clk = 1'b0;
    logic       rtc_clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       evt_sec = 0, evt_min = 0, evt_hour = 0, evt_day = 0;
    logic       alarm_hit = 0, period_hit = 0, upd_soon = 0, stop_req = 0;
    logic       wr_en = 0, wr_sel = 0;
    logic [7:0] wr_data = '0;
    logic [7:0] status, irq_en;
    logic       run, alarm_irq_n, timer_irq_n;

    int n_vec = 0;
    int n_bad = 0;

    // model state
    bit       m_pwr = 1;
    bit       m_alm = 0;
    bit [3:0] m_ev  = 0;
    bit       m_ie_a = 0;
    bit       m_ie_t = 0;

    always #2.5 clk = ~clk;      // 200 MHz
    always #100 rtc_clk = ~rtc_clk;

    rtc_stat_ctrl #(.PULSE_W(PW)) i_rtc_stat_ctrl (
        .clk(clk), .rst_n(rst_n), .rtc_clk(rtc_clk),
        .evt_sec_i(evt_sec), .evt_min_i(evt_min), .evt_hour_i(evt_hour),
        .evt_day_i(evt_day), .alarm_hit_i(alarm_hit), .period_hit_i(period_hit),
        .upd_soon_i(upd_soon), .stop_req_i(stop_req),
        .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
        .status_o(status), .irq_en_o(irq_en), .run_o(run),
        .alarm_irq_n_o(alarm_irq_n), .timer_irq_n_o(timer_irq_n)
    );

    function automatic logic [7:0] exp_stat(bit run_b, bit busy_b);
        return {m_pwr, m_alm, m_ev, run_b, busy_b};
    endfunction

    function automatic logic [7:0] exp_ie();
        return {4'b0, m_ie_a, m_ie_t, 2'b0};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic bus_write(input bit sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 0;
        if (sel) begin
            m_ie_a = d[3]; m_ie_t = d[2];
        end else begin
            if (d[7]) m_pwr = 0;
            if (d[6]) m_alm = 0;
        end
    endtask

    // strobes: {period, alarm, day, hour, min, sec}; returns timer low cycles
    task automatic rtc_event(input logic [5:0] m, output int low_cnt);
        int cnt = 0;
        @(negedge rtc_clk);
        {period_hit, alarm_hit, evt_day, evt_hour, evt_min, evt_sec} = m;
        fork
            begin
                @(negedge rtc_clk);
                {period_hit, alarm_hit, evt_day, evt_hour, evt_min, evt_sec} = '0;
            end
            begin
                repeat (PW + 60) begin
                    @(negedge clk);
                    if (!timer_irq_n) cnt++;
                end
            end
        join
        low_cnt = cnt;
        if (|m[3:0]) m_ev = m[3:0];
        if (m[4]) m_alm = 1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int lc;
        int wait_c;
        void'($urandom(32'd2024));

        // R1: reset values
        #20;
        check("R1 status", status, 8'h80);
        check("R1 irq_en", irq_en, 8'h00);
        check("R1 run", run, 1'b0);
        check("R1 irq lines", {alarm_irq_n, timer_irq_n}, 2'b11);
        repeat (10) @(negedge clk);
        rst_n = 1;

        // R6: clock starts running, RUN visible
        repeat (3) @(negedge rtc_clk);
        check("R6 run after reset", run, 1'b1);
        check("R6 status run", status, exp_stat(1, 0));

        // R2: write 0 keeps power-up, write 1 clears
        bus_write(0, 8'h3F);
        check("R2 zero write ignored", status[7], 1'b1);
        bus_write(0, 8'h80);
        check("R2 write-one clears", status, exp_stat(1, 0));

        // R9: enable register random writes
        for (int i = 0; i < 8; i++) begin
            logic [7:0] d = 8'($urandom);
            bus_write(1, d);
            check("R9 enable write", irq_en, exp_ie());
        end

        // R3: alarm without enable
        bus_write(1, 8'h00);
        rtc_event(6'b010000, lc);
        check("R3 flag without enable", status[6], 1'b1);
        check("R3 no irq without enable", alarm_irq_n, 1'b1);
        bus_write(0, 8'h40);
        check("R4 flag cleared", status[6], 1'b0);

        // R3/R4: alarm with enable, held level
        bus_write(1, 8'h08);
        rtc_event(6'b010000, lc);
        check("R3 irq with enable", alarm_irq_n, 1'b0);
        repeat (150) @(negedge clk);
        check("R4 held while idle", alarm_irq_n, 1'b0);
        bus_write(0, 8'hBF);
        check("R4 held after zero write", {alarm_irq_n, status[6]}, 2'b01);
        bus_write(1, 8'h00);
        check("R4 held after disable", alarm_irq_n, 1'b0);
        bus_write(0, 8'h40);
        check("R4 released by write-one", {alarm_irq_n, status[6]}, 2'b10);

        // R5: timer pulse width, disabled case
        bus_write(1, 8'h04);
        rtc_event(6'b100000, lc);
        check("R5 pulse width", lc, PW);
        bus_write(1, 8'h00);
        rtc_event(6'b100000, lc);
        check("R5 no pulse disabled", lc, 0);

        // R8: random time strobe combinations
        for (int i = 0; i < 10; i++) begin
            logic [3:0] ev = 4'($urandom);
            if (ev == 0) ev = 4'b0001;
            rtc_event({2'b00, ev}, lc);
            check("R8 event bits", status, exp_stat(1, 0));
        end
        bus_write(0, 8'h3C);
        check("R8 events not writable", status, exp_stat(1, 0));

        // R7: BUSY ahead of second strobe
        @(negedge rtc_clk);
        upd_soon = 1;
        repeat (4) @(negedge clk);
        check("R7 busy before update", status[0], 1'b1);
        rtc_event(6'b000001, lc);
        upd_soon = 0;
        repeat (4) @(negedge clk);
        check("R7 busy cleared", status, exp_stat(1, 0));

        // R6: stop within one slow period
        @(negedge clk);
        stop_req = 1;
        wait_c = 0;
        while (run && wait_c < 100) begin
            @(negedge clk);
            wait_c++;
        end
        check("R6 stop latency", (wait_c <= 40), 1'b1);
        repeat (4) @(negedge clk);
        check("R6 RUN bit low", status, exp_stat(0, 0));
        stop_req = 0;
        wait_c = 0;
        while (!run && wait_c < 100) begin
            @(negedge clk);
            wait_c++;
        end
        check("R6 restart latency", (wait_c <= 40), 1'b1);
        repeat (4) @(negedge clk);
        check("R6 RUN bit high", status[1], 1'b1);

        // mixed random alarm/timer rounds
        for (int i = 0; i < 8; i++) begin
            logic [7:0] d = 8'($urandom);
            bus_write(1, d);
            rtc_event(6'b110000, lc);
            check("R5 random pulse", lc, m_ie_t ? PW : 0);
            check("R3 random alarm", {alarm_irq_n, status[6]}, {!m_ie_a, 1'b1});
            bus_write(0, 8'h40);
            check("R4 random clear", {alarm_irq_n, status[6]}, 2'b10);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule